// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block connects a simple synchronous host to an asynchronous dynamic memory of 65536 locations, each 4 bits wide. The memory has only eight address pins. The host presents a 16-bit address, a read or write flag and 4-bit write data. The controller splits the address into two halves that share the eight pins. The low byte is sent first as the row and is latched by the falling row strobe. The high byte follows as the column and is latched by the falling column strobe. The controller returns read data together with a single-cycle completion pulse.

A per-bit two-way selector picks which half of the address reaches the pins. The selector moves to the column half only after the row strobe has fallen. A third path puts the refresh row pointer on the pins instead.

A refresh timer raises a pending flag once per refresh interval. The interval is sized so that 256 row refreshes cover the whole retention window. Each refresh is row-strobe only, and the 8-bit row pointer advances by one after each refresh. A pending refresh is served before the next host access. It never cuts short an access that has already started.

The timing values are parameters:
- T_RCD: row-to-column delay.
- T_CAS: column-low access time.
- T_RP: row precharge.
- T_RAS: row-low time of a refresh.
- REF_PERIOD: refresh interval.

Top module: `dram_mux_ctrl`

## Requirements
- R1: When the row strobe falls on a host access, the pins carry address bits 7..0. When the column strobe falls, the pins carry address bits 15..8. The column half reaches the pins only while the row strobe is low.
- R2: The column strobe is low only while the row strobe is low. A write is stored in the memory only at the falling column strobe.
- R3: On a write, write-enable is low and the write data is driven (data-enable high) at least one clock before the column strobe falls. Both stay in place until the strobe rises.
- R4: On a read, output-enable falls one clock after the column strobe and is low only while the column strobe is low. Read data is sampled after T_CAS clocks of column-low. It appears on rdata with a one-cycle done pulse, exactly T_RCD+T_CAS+2 clocks after the accepting edge.
- R5: Write-enable and output-enable are never low in the same clock.
- R6: Between any two row-low periods, the row strobe stays high for at least T_RP clocks.
- R7: The refresh pending flag is raised every REF_PERIOD clocks. A refresh drives the row pointer on the pins and holds the row strobe low for T_RAS clocks, with column strobe, write-enable and output-enable all high. Refreshed rows follow 0, 1, 2, ... modulo 256.
- R8: A pending refresh is served before any new host access and never aborts an access in progress. Consecutive refreshes are REF_PERIOD clocks apart, plus or minus the length of one host access.
- R9: ready is high only when the controller is idle and no refresh is pending. A request is accepted on a clock edge where req_valid and ready are both high. ready then stays low through the done cycle.
- R10: A request presented while ready is low is ignored and leaves the memory contents unchanged.
- R11: During and after reset, all four strobes are high, data-enable is low, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host address; bits 7..0 row, 15..8 column |
| req_wdata | input | 4 | Write data |
| ready | output | 1 | Controller can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read data, valid with done |
| dram_addr | output | 8 | Multiplexed address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and chip select, active low |
| dram_we_n | output | 1 | Write-enable, active low |
| dram_oe_n | output | 1 | Output-enable, active low |
| dram_dq_out | output | 4 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 4 | Data from the memory |

## Verification
Refresh timing and host accesses can land in the same cycle. The timer expires while an access is mid-flight, or a refresh is still pending at the moment the host wants to start a new access. The bench provokes this by running long sweeps of back-to-back reads and writes, using a short refresh interval that is not a multiple of the access length. The collision point therefore drifts across every phase of the access. The outcome is judged at the pins by a memory model: every access reads back its own data, every refresh is row-only and follows the expected row order, and refreshes stay within the allowed spacing.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RCD,
    ST_CAS,
    ST_PRE,
    ST_RSET,
    ST_RRAS
  } dmc_state_e;
endpackage

// File: rtl/dmc_refresh.sv
module dmc_refresh #(
  parameter int REF_PERIOD = 1562,
  parameter int ROW_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  output logic             pend,
  output logic [ROW_W-1:0] row_ptr
);
  localparam int TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1;

  logic [TW-1:0] tcnt;
  logic          wrap;

  assign wrap = (tcnt == TW'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
    end else if (wrap) begin
      tcnt <= '0;
    end else begin
      tcnt <= tcnt + TW'(1);
    end
  end

  // a new expiry wins over an acknowledge in the same clock
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (wrap) begin
      pend <= 1'b1;
    end else if (ack) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_ptr <= '0;
    end else if (ack) begin
      row_ptr <= row_ptr + ROW_W'(1);
    end
  end

  p_pend_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pend);

  p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
    ack |=> (row_ptr == $past(row_ptr) + ROW_W'(1)));
endmodule

// File: rtl/dmc_addr_mux.sv
module dmc_addr_mux #(
  parameter int ROW_W = 8
) (
  input  logic [2*ROW_W-1:0] addr,
  input  logic               col_sel,
  input  logic               ref_sel,
  input  logic [ROW_W-1:0]   ref_row,
  output logic [ROW_W-1:0]   pins
);
  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    logic half;
    assign half    = col_sel ? addr[ROW_W+i] : addr[i];
    assign pins[i] = ref_sel ? ref_row[i] : half;
  end
endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 4,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ref_pend,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              col_sel,
  output logic              ref_sel,
  output logic              ref_ack,
  output logic [ADDR_W-1:0] addr_q
);
  localparam int TM1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2   = (T_RP > T_RAS) ? T_RP : T_RAS;
  localparam int TMAX  = (TM1 > TM2) ? TM1 : TM2;
  localparam int CNT_W = $clog2(TMAX + 1);

  dmc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q;

  assign ready = (state == ST_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
      done    <= 1'b0;
      rdata   <= '0;
      col_sel <= 1'b0;
      ref_sel <= 1'b0;
      ref_ack <= 1'b0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      done    <= 1'b0;
      ref_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_pend) begin
            ref_sel <= 1'b1;
            state   <= ST_RSET;
          end else if (req_valid) begin
            addr_q  <= req_addr;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            state   <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          ras_n  <= 1'b0;
          we_n   <= !wr_q;
          dq_oe  <= wr_q;
          dq_out <= wdata_q;
          cnt    <= CNT_W'(T_RCD - 1);
          state  <= ST_RCD;
        end
        ST_RCD: begin
          col_sel <= 1'b1;
          if (cnt == '0) begin
            cas_n <= 1'b0;
            cnt   <= CNT_W'(T_CAS - 1);
            state <= ST_CAS;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_CAS: begin
          if (!wr_q) oe_n <= 1'b0;
          if (cnt == '0) begin
            if (!wr_q) rdata <= dq_in;
            done    <= 1'b1;
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            we_n    <= 1'b1;
            oe_n    <= 1'b1;
            dq_oe   <= 1'b0;
            col_sel <= 1'b0;
            cnt     <= CNT_W'(T_RP - 1);
            state   <= ST_PRE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - CNT_W'(1);
        end
        ST_RSET: begin
          ras_n <= 1'b0;
          cnt   <= CNT_W'(T_RAS - 1);
          state <= ST_RRAS;
        end
        ST_RRAS: begin
          if (cnt == '0) begin
            ras_n   <= 1'b1;
            ref_ack <= 1'b1;
            ref_sel <= 1'b0;
            cnt     <= CNT_W'(T_RP - 1);
            state   <= ST_PRE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  p_oe_in_cas_r4: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> !cas_n);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ref_ras_only_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RRAS) |-> (cas_n && we_n && oe_n));

  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid) |=> !ready);

  p_col_after_ras_r1: assert property (@(posedge clk) disable iff (rst)
    col_sel |-> !ras_n);

  p_precharge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n);
endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 4,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 2,
  parameter int T_RAS      = 4,
  parameter int REF_PERIOD = 1562
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                ready,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic [ADDR_W/2-1:0] dram_addr,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [DATA_W-1:0]   dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DATA_W-1:0]   dram_dq_in
);
  localparam int ROW_W = ADDR_W / 2;

  logic              ref_pend;
  logic              ref_ack;
  logic [ROW_W-1:0]  ref_row;
  logic              col_sel;
  logic              ref_sel;
  logic [ADDR_W-1:0] addr_q;

  dmc_refresh #(
    .REF_PERIOD(REF_PERIOD),
    .ROW_W     (ROW_W)
  ) u_ref (
    .clk    (clk),
    .rst    (rst),
    .ack    (ref_ack),
    .pend   (ref_pend),
    .row_ptr(ref_row)
  );

  dmc_seq #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .T_RCD (T_RCD),
    .T_CAS (T_CAS),
    .T_RP  (T_RP),
    .T_RAS (T_RAS)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .ref_pend (ref_pend),
    .dq_in    (dram_dq_in),
    .ready    (ready),
    .done     (done),
    .rdata    (rdata),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .we_n     (dram_we_n),
    .oe_n     (dram_oe_n),
    .dq_out   (dram_dq_out),
    .dq_oe    (dram_dq_oe),
    .col_sel  (col_sel),
    .ref_sel  (ref_sel),
    .ref_ack  (ref_ack),
    .addr_q   (addr_q)
  );

  dmc_addr_mux #(
    .ROW_W(ROW_W)
  ) u_mux (
    .addr   (addr_q),
    .col_sel(col_sel),
    .ref_sel(ref_sel),
    .ref_row(ref_row),
    .pins   (dram_addr)
  );
endmodule

// File: tb/sim_dram_mux_ctrl.sv
`timescale 1ns/1ps
module sim_dram_mux_ctrl;
  localparam int RCD = 2;
  localparam int CAC = 3;
  localparam int RP  = 2;
  localparam int RAS = 3;
  localparam int REF = 64;
  localparam int HOST_SLACK = 16;
  localparam logic [15:0] SPAM_ADDR = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic        ready, done;
  logic [3:0]  rdata;
  logic [7:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [3:0]  dram_dq_out;
  logic [3:0]  dq_in_r = '0;

  int tests = 0;
  int fails = 0;
  int pcyc  = 0;

  always #5 clk = ~clk;

  dram_mux_ctrl #(
    .ADDR_W(16), .DATA_W(4), .T_RCD(RCD), .T_CAS(CAC),
    .T_RP(RP), .T_RAS(RAS), .REF_PERIOD(REF)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
    .rdata(rdata), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dq_in_r)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // host-side expectations shared with the pin monitor
  logic [15:0] exp_addr = '0;
  logic        exp_wr   = 1'b0;
  logic [3:0]  exp_d    = '0;
  bit          host_active = 1'b0;

  // memory model and pin monitor
  logic [3:0] mem [int];
  logic [7:0] cur_row = '0;
  logic [7:0] cur_col = '0;
  bit   p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1, p_started = 1'b0;
  bit   cas_seen = 1'b0, we_seen = 1'b0, oe_seen = 1'b0;
  int   ras_low = 0, ras_high = 1000, ncyc = 0;
  int   nref = 0, last_ref_fall = -1, ref_fall_cyc = 0;
  int   last_row_ref [256];
  logic [7:0] ref_expect = '0;
  int   we_oe_viol = 0;

  initial for (int i = 0; i < 256; i++) last_row_ref[i] = -1;

  always @(negedge clk) begin
    int key;
    ncyc++;
    if (rst) begin
      p_ras = 1'b1; p_cas = 1'b1; p_we = 1'b1;
    end else begin
      if (!dram_we_n && !dram_oe_n) we_oe_viol++;
      if (!dram_oe_n && dram_cas_n) begin
        chk(1'b0, "R4 oe low without cas", 0, 1);
      end
      if (!dram_cas_n && dram_ras_n) chk(1'b0, "R2 cas low while ras high", 1, 0);
      // row strobe fall
      if (p_ras && !dram_ras_n) begin
        chk(ras_high >= RP, "R6 precharge length", ras_high, RP);
        cur_row  = dram_addr;
        cas_seen = 1'b0; we_seen = 1'b0; oe_seen = 1'b0;
        ras_low  = 0;
        ref_fall_cyc = ncyc;
        if (host_active) chk(dram_addr == exp_addr[7:0], "R1 row on pins", dram_addr, exp_addr[7:0]);
      end
      // column strobe fall
      if (p_cas && !dram_cas_n) begin
        cur_col = dram_addr;
        chk(dram_addr == exp_addr[15:8], "R1 column on pins", dram_addr, exp_addr[15:8]);
        chk(!dram_ras_n, "R2 ras low at cas fall", dram_ras_n, 0);
        if (exp_wr) begin
          chk(!dram_we_n && !p_we, "R3 we low before cas", p_we, 0);
          chk(dram_dq_oe && dram_dq_out == exp_d, "R3 write data driven", dram_dq_out, exp_d);
          key = {cur_col, cur_row};
          if (!dram_we_n) mem[key] = dram_dq_out;
        end else begin
          chk(dram_oe_n, "R4 oe one clock after cas", dram_oe_n, 1);
        end
      end
      if (!dram_ras_n) begin
        ras_low++;
        if (!dram_cas_n) cas_seen = 1'b1;
        if (!dram_we_n)  we_seen  = 1'b1;
        if (!dram_oe_n)  oe_seen  = 1'b1;
        ras_high = 0;
      end else begin
        ras_high++;
      end
      // row strobe rise
      if (!p_ras && dram_ras_n) begin
        if (!cas_seen) begin
          chk(!we_seen && !oe_seen, "R7 refresh is ras-only", we_seen, 0);
          chk(cur_row == ref_expect, "R7 refresh row order", cur_row, ref_expect);
          chk(ras_low == RAS, "R7 refresh ras length", ras_low, RAS);
          if (last_ref_fall >= 0)
            chk((ref_fall_cyc - last_ref_fall <= REF + HOST_SLACK) &&
                (ref_fall_cyc - last_ref_fall >= REF - HOST_SLACK),
                "R8 refresh spacing", ref_fall_cyc - last_ref_fall, REF);
          if (last_row_ref[cur_row] >= 0)
            chk(ref_fall_cyc - last_row_ref[cur_row] <= 256 * REF + HOST_SLACK,
                "R8 row retention", ref_fall_cyc - last_row_ref[cur_row], 256 * REF);
          last_row_ref[cur_row] = ref_fall_cyc;
          last_ref_fall = ref_fall_cyc;
          ref_expect = ref_expect + 8'd1;
          nref++;
        end else begin
          chk(ras_low == RCD + CAC, "R8 host access not cut short", ras_low, RCD + CAC);
        end
      end
      key = {cur_col, cur_row};
      dq_in_r = (!dram_cas_n && !dram_oe_n && mem.exists(key)) ? mem[key] : 4'h0;
      p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n;
    end
  end

  task automatic op(input bit wr, input logic [15:0] a, input logic [3:0] d,
                    input bit spam, output logic [3:0] q);
    int lat;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_addr = a; exp_wr = wr; exp_d = d;
    @(posedge clk);
    host_active = 1'b1;
    @(negedge clk);
    lat = 1;
    chk(!ready, "R9 ready low after accept", ready, 0);
    if (spam) begin
      req_write = 1'b1; req_addr = SPAM_ADDR; req_wdata = 4'hF;
    end else begin
      req_valid = 1'b0;
    end
    while (!done) begin
      @(negedge clk);
      lat++;
      chk(!ready, "R9 ready low until done", ready, 0);
    end
    chk(lat == RCD + CAC + 2, "R4 done latency", lat, RCD + CAC + 2);
    q = rdata;
    req_valid = 1'b0;
    host_active = 1'b0;
    @(negedge clk);
    chk(!done, "R4 done single pulse", done, 0);
  endtask

  function automatic logic [15:0] addr_of(input int k);
    logic [7:0] row;
    row = 8'((k * 37 + 5) & 255);
    return {8'(k & 255), row};
  endfunction

  function automatic logic [3:0] data_of(input int k, input int salt);
    return 4'((k * 5 + (k >> 3) + salt) & 15);
  endfunction

  always @(posedge clk) begin
    pcyc++;
    if (pcyc == 150000) begin
      chk(1'b0, "watchdog expired", pcyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] q;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R11 strobes high in reset", 0, 1);
    chk(!dram_dq_oe && !done, "R11 outputs idle in reset", dram_dq_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ready, "R11 ready after reset", ready, 1);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R11 strobes high after reset", 0, 1);
    chk(!done && !dram_dq_oe, "R11 done and drive low", done, 0);

    // every row and every column once
    for (int k = 0; k < 256; k++) op(1'b1, addr_of(k), data_of(k, 0), 1'b0, q);
    for (int k = 0; k < 256; k++) begin
      op(1'b0, addr_of(k), 4'h0, 1'b0, q);
      chk(q == data_of(k, 0), "R4 read back sweep", q, data_of(k, 0));
    end
    // write immediately followed by read of the same cell
    for (int k = 0; k < 256; k += 2) begin
      op(1'b1, addr_of(k), data_of(k, 9), 1'b0, q);
      op(1'b0, addr_of(k), 4'h0, 1'b0, q);
      chk(q == data_of(k, 9), "R2 write then read", q, data_of(k, 9));
    end
    for (int k = 1; k < 256; k += 2) begin
      op(1'b0, addr_of(k), 4'h0, 1'b0, q);
      chk(q == data_of(k, 0), "R2 untouched cells", q, data_of(k, 0));
    end

    // requests held while busy must be ignored
    op(1'b1, SPAM_ADDR, 4'h6, 1'b0, q);
    for (int k = 0; k < 8; k++) op(1'b0, addr_of(k), 4'h0, 1'b1, q);
    op(1'b0, SPAM_ADDR, 4'h0, 1'b0, q);
    chk(q == 4'h6, "R10 busy request ignored", q, 6);

    // idle run so refresh sweeps complete without host traffic
    while (nref < 600) @(negedge clk);
    chk(nref >= 600, "R7 refresh count", nref, 600);
    chk(we_oe_viol == 0, "R5 we and oe exclusive", we_oe_viol, 0);
    begin
      int missing;
      missing = 0;
      for (int r = 0; r < 256; r++) if (last_row_ref[r] < 0) missing++;
      chk(missing == 0, "R8 all rows refreshed", missing, 0);
    end
    chk((nref >= ncyc / REF - 2) && (nref <= ncyc / REF + 1), "R7 refresh rate", nref, ncyc / REF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule